// File: doc/BRIEF.md
# Dual-Input XOR Capture Trigger

This block creates capture strobes for a register that takes a snapshot of an auxiliary timer count. The strobe comes from one of two sources. The first source is a single dedicated trigger pin. The second source is a pair of pins, and the block watches the exclusive-OR of that pair. A two-bit edge mode sets which kind of change fires a capture. Mode zero turns capture off.

All three pins are asynchronous to the system clock. Each pin passes through a synchronizer chain. A change is found by comparing the synchronized level with the level from one cycle earlier. On a qualifying change, the block copies the timer value into the capture register and raises an interrupt request for one clock. The timer itself is outside this block, and so are interrupt arbitration and any register access. The configuration arrives on plain input ports.

Top module: `dual_xor_capture`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cap_value` is 0 and `cap_irq` is 0.
- R2: When `edge_mode` is 2'b00, no capture happens for any pin activity, with either setting of `sel_pair`.
- R3: With `sel_pair`=0 and `edge_mode`=2'b01, a low-to-high change on `trig_pin` causes a capture. A high-to-low change does not.
- R4: With `sel_pair`=0 and `edge_mode`=2'b10, a high-to-low change on `trig_pin` causes a capture. A low-to-high change does not.
- R5: With `sel_pair`=0 and `edge_mode`=2'b11, a change of `trig_pin` in either direction causes a capture.
- R6: With `sel_pair`=1 and `edge_mode`=2'b01, a capture happens when `pair_a` XOR `pair_b` goes from 0 to 1, that is, when the pins go from equal to unequal levels.
- R7: With `sel_pair`=1 and `edge_mode`=2'b10, a capture happens when `pair_a` XOR `pair_b` goes from 1 to 0, that is, when the pins go from unequal to equal levels.
- R8: With `sel_pair`=1 and `edge_mode`=2'b11, any change of either pair pin causes a capture. This includes both pins changing in the same sampled cycle.
- R9: With `sel_pair`=1 and `edge_mode` of 2'b01 or 2'b10, both pair pins changing in the same sampled cycle leave the XOR unchanged and cause no capture.
- R10: The pins of the source that is not selected have no effect. With `sel_pair`=0, `pair_a` and `pair_b` are ignored. With `sel_pair`=1, `trig_pin` is ignored.
- R11: Each capture sets `cap_irq` high for exactly one clock. On that same edge, `cap_value` loads the `timer_val` sampled at that edge. When `cap_irq` is low, `cap_value` holds its value.
- R12: A pin change that is stable before rising edge k (with 2 synchronizer stages) produces `cap_irq` after rising edge k+2. The captured value is the `timer_val` presented just before edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_pair | input | 1 | Trigger source: 0 selects the dedicated pin, 1 selects the pin pair |
| edge_mode | input | 2 | 00 off, 01 up, 10 down, 11 both |
| trig_pin | input | 1 | Dedicated asynchronous trigger pin |
| pair_a | input | 1 | First asynchronous pair pin |
| pair_b | input | 1 | Second asynchronous pair pin |
| timer_val | input | TW | Running timer count to be captured |
| cap_value | output | TW | Capture register |
| cap_irq | output | 1 | One-clock interrupt request per capture |

## Verification
The checker tests these rules on every cycle:
- A pulse never follows a cycle in which the mode was off.
- The capture register holds its value between pulses and loads the timer on each pulse.
- A synchronized XOR rise, or a synchronized rise on the dedicated pin, in the matching mode is always followed by a pulse.
- Both pair pins changing in the same cycle is always silent in the XOR modes.

The bench scenarios show the rest:
- The exact latency from a pin change, measured against a free-running timer.
- Each source being ignored while the other source is selected.
- Pulses on back-to-back cycles.
- The complete sequence of equal-to-unequal and unequal-to-equal changes across every mode.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_UP   = 2'b01,
    EDGE_DN   = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int PIN_TRIG = 0;
  localparam int PIN_A    = 1;
  localparam int PIN_B    = 2;
  localparam int NUM_PINS = 3;
endpackage

// File: rtl/dxc_sync.sv
module dxc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] now_q,
  output logic [WIDTH-1:0] was_q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign now_q = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) was_q <= '0;
    else     was_q <= now_q;
  end
endmodule

// File: rtl/dxc_event.sv
module dxc_event
  import dxc_pkg::*;
(
  input  logic                sel_pair,
  input  edge_mode_e          mode,
  input  logic [NUM_PINS-1:0] now_q,
  input  logic [NUM_PINS-1:0] was_q,
  output logic                fire
);
  logic up_one, dn_one, up_x, dn_x, any_pair;
  logic x_now, x_was;

  always_comb begin
    up_one   = now_q[PIN_TRIG] & ~was_q[PIN_TRIG];
    dn_one   = ~now_q[PIN_TRIG] & was_q[PIN_TRIG];
    x_now    = now_q[PIN_A] ^ now_q[PIN_B];
    x_was    = was_q[PIN_A] ^ was_q[PIN_B];
    up_x     = x_now & ~x_was;
    dn_x     = ~x_now & x_was;
    any_pair = (now_q[PIN_A] != was_q[PIN_A]) | (now_q[PIN_B] != was_q[PIN_B]);
    unique case (mode)
      EDGE_UP:   fire = sel_pair ? up_x : up_one;
      EDGE_DN:   fire = sel_pair ? dn_x : dn_one;
      EDGE_BOTH: fire = sel_pair ? any_pair : (up_one | dn_one);
      default:   fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/dxc_capreg.sv
module dxc_capreg #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [TW-1:0] timer_val,
  output logic [TW-1:0] cap_value,
  output logic          cap_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_value <= '0;
      cap_irq   <= 1'b0;
    end else begin
      cap_irq <= fire;
      if (fire) cap_value <= timer_val;
    end
  end
endmodule

// File: rtl/dual_xor_capture.sv
module dual_xor_capture
  import dxc_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_pair,
  input  logic [1:0]    edge_mode,
  input  logic          trig_pin,
  input  logic          pair_a,
  input  logic          pair_b,
  input  logic [TW-1:0] timer_val,
  output logic [TW-1:0] cap_value,
  output logic          cap_irq
);
  logic [NUM_PINS-1:0] raw_pins;
  logic [NUM_PINS-1:0] sync_cur;
  logic [NUM_PINS-1:0] sync_prev;
  logic                fire;

  always_comb begin
    raw_pins           = '0;
    raw_pins[PIN_TRIG] = trig_pin;
    raw_pins[PIN_A]    = pair_a;
    raw_pins[PIN_B]    = pair_b;
  end

  dxc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw   (raw_pins),
    .now_q (sync_cur),
    .was_q (sync_prev)
  );

  dxc_event u_event (
    .sel_pair (sel_pair),
    .mode     (edge_mode_e'(edge_mode)),
    .now_q    (sync_cur),
    .was_q    (sync_prev),
    .fire     (fire)
  );

  dxc_capreg #(.TW(TW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .timer_val (timer_val),
    .cap_value (cap_value),
    .cap_irq   (cap_irq)
  );
endmodule

// File: rtl/dual_xor_capture_chk.sv
module dual_xor_capture_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_pair,
  input logic [1:0]    edge_mode,
  input logic [TW-1:0] timer_val,
  input logic [TW-1:0] cap_value,
  input logic          cap_irq,
  input logic [2:0]    sync_cur,
  input logic [2:0]    sync_prev
);
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    cap_irq |-> ($past(edge_mode) != 2'b00)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cap_irq |-> $stable(cap_value)); // R11

  AST_LOAD_TIMER: assert property (@(posedge clk) disable iff (rst)
    cap_irq |-> (cap_value == $past(timer_val))); // R11

  AST_TRIG_RISE: assert property (@(posedge clk) disable iff (rst)
    (!sel_pair && edge_mode == 2'b01 && sync_cur[0] && !sync_prev[0]) |=> cap_irq); // R3

  AST_XOR_RISE: assert property (@(posedge clk) disable iff (rst)
    (sel_pair && edge_mode == 2'b01 && (sync_cur[1] ^ sync_cur[2])
     && !(sync_prev[1] ^ sync_prev[2])) |=> cap_irq); // R6

  AST_TWIN_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel_pair && edge_mode != 2'b11 && sync_cur[1] != sync_prev[1]
     && sync_cur[2] != sync_prev[2]) |=> !cap_irq); // R9
endmodule

bind dual_xor_capture dual_xor_capture_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel_pair  (sel_pair),
  .edge_mode (edge_mode),
  .timer_val (timer_val),
  .cap_value (cap_value),
  .cap_irq   (cap_irq),
  .sync_cur  (sync_cur),
  .sync_prev (sync_prev)
);

// File: tb/dual_xor_capture_tb.sv
module dual_xor_capture_tb;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_pair = 1'b0;
  logic [1:0]    edge_mode = 2'b00;
  logic          trig_pin = 1'b0;
  logic          pair_a = 1'b0;
  logic          pair_b = 1'b0;
  logic [TW-1:0] timer_val = '0;
  logic [TW-1:0] cap_value;
  logic          cap_irq;

  int checks = 0;
  int failures = 0;
  logic [TW-1:0] exp_q [$];
  string         tag_q [$];
  logic [TW-1:0] last_cap = '0;
  bit            mon_on = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) timer_val <= timer_val + 1'b1;

  dual_xor_capture #(.TW(TW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .sel_pair(sel_pair), .edge_mode(edge_mode),
    .trig_pin(trig_pin), .pair_a(pair_a), .pair_b(pair_b),
    .timer_val(timer_val), .cap_value(cap_value), .cap_irq(cap_irq)
  );

  // Monitor: every pulse must match the oldest expected capture.
  always @(negedge clk) begin
    if (mon_on && cap_irq) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R11 unexpected capture: actual=%h expected=none", cap_value);
      end else begin
        logic [TW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (cap_value !== e) begin
          failures++;
          $display("FAIL %s R12 capture value: actual=%h expected=%h", t, cap_value, e);
        end
      end
    end
  end

  task automatic set_cfg(input logic src, input logic [1:0] mode);
    @(negedge clk);
    sel_pair  = src;
    edge_mode = mode;
    repeat (2) @(negedge clk);
  endtask

  // Driver: change pins at a negedge, queue the expected capture, let it settle.
  task automatic drive(input logic t, input logic a, input logic b,
                       input bit fires, input string tag);
    @(negedge clk);
    trig_pin = t;
    pair_a   = a;
    pair_b   = b;
    if (fires) begin
      exp_q.push_back(timer_val + TW'(2));
      tag_q.push_back(tag);
      last_cap = timer_val + TW'(2);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic check_hold(input string tag);
    checks++;
    if (cap_value !== last_cap) begin
      failures++;
      $display("FAIL %s register disturbed: actual=%h expected=%h", tag, cap_value, last_cap);
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    checks++;
    if (cap_value !== '0 || cap_irq !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: actual=%h/%b expected=0/0", cap_value, cap_irq);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (cap_value !== '0 || cap_irq !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset: actual=%h/%b expected=0/0", cap_value, cap_irq);
    end
    mon_on = 1'b1;

    // R2: mode off, both sources
    drive(1, 0, 0, 0, "R2"); drive(0, 0, 0, 0, "R2"); check_hold("R2");
    set_cfg(1, 2'b00);
    drive(0, 1, 0, 0, "R2"); drive(0, 0, 0, 0, "R2"); check_hold("R2");

    // R3: dedicated pin, rising
    set_cfg(0, 2'b01);
    drive(1, 0, 0, 1, "R3"); drive(0, 0, 0, 0, "R3"); check_hold("R3");
    // R4: falling
    set_cfg(0, 2'b10);
    drive(1, 0, 0, 0, "R4"); check_hold("R4"); drive(0, 0, 0, 1, "R4");
    // R5: both
    set_cfg(0, 2'b11);
    drive(1, 0, 0, 1, "R5"); drive(0, 0, 0, 1, "R5");
    // R10: pair ignored with dedicated pin selected
    drive(0, 1, 0, 0, "R10"); drive(0, 1, 1, 0, "R10"); drive(0, 0, 0, 0, "R10");
    check_hold("R10");

    // R6: XOR 0->1
    set_cfg(1, 2'b01);
    drive(0, 1, 0, 1, "R6"); drive(0, 1, 1, 0, "R6");
    drive(0, 0, 1, 1, "R6"); drive(0, 0, 0, 0, "R6"); check_hold("R6");
    // R7: XOR 1->0
    set_cfg(1, 2'b10);
    drive(0, 1, 0, 0, "R7"); check_hold("R7"); drive(0, 0, 0, 1, "R7");
    drive(0, 0, 1, 0, "R7"); drive(0, 0, 0, 1, "R7");
    // R9: twin toggles in XOR modes
    drive(0, 1, 1, 0, "R9"); drive(0, 0, 0, 0, "R9"); check_hold("R9");
    set_cfg(1, 2'b01);
    drive(0, 1, 1, 0, "R9"); drive(0, 0, 0, 0, "R9"); check_hold("R9");
    // R8: any change of the pair
    set_cfg(1, 2'b11);
    drive(0, 1, 0, 1, "R8"); drive(0, 1, 1, 1, "R8"); drive(0, 0, 0, 1, "R8");
    // R10: dedicated pin ignored with pair selected
    drive(1, 0, 0, 0, "R10"); drive(0, 0, 0, 0, "R10"); check_hold("R10");

    // R11/R12: changes on consecutive cycles give consecutive pulses
    @(negedge clk);
    pair_a = 1'b1;
    exp_q.push_back(timer_val + TW'(2)); tag_q.push_back("R11");
    @(negedge clk);
    pair_a = 1'b0;
    exp_q.push_back(timer_val + TW'(2)); tag_q.push_back("R11");
    last_cap = timer_val + TW'(2);
    repeat (6) @(negedge clk);
    check_hold("R11");

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R11 missing captures: actual=%0d pending expected=0", exp_q.size());
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule